// File: doc/BRIEF.md
# Command-Prefixed Serial Register Port

This block is the device side of a four-wire serial port with an active-low select, a data input, a serial clock and a single output that carries both read data and an active-low "result ready" flag. Every access is armed by an 8-bit command byte. The byte says whether a read or a write follows and which of eight registers it targets. The data phase that follows then shifts a full register word in from the data input or out on the output line. The bus lines are sampled on the system clock through a short synchronizer, so the serial clock must run several times slower than the system clock.

The block drives a plain register-file port: an address, a write strobe with its word, a read strobe, and a read-data input that is taken as valid in the cycle after the address settles. The conversion logic reports each new result with a one-cycle pulse. The block holds a ready flag from that pulse until a complete read of the data register. While the port is selected and not shifting data out, the output line shows the inverse of that flag. A streaming mode, chosen by a level input, drops the command byte: whenever a result is ready, the master clocks the data register out directly, and each result comes out only once.

Top module: `cmd_serial_port`

## Requirements
- R1: After reset the port waits for a command byte, no register strobe is issued, the output line is high and its enable is low.
- R2: The command byte is shifted in most significant bit first. Bit 7 must be 0 for the byte to be accepted. Bit 6 selects read (1) or write (0). Bits 5:3 give the register address. Bits 2:0 have no effect.
- R3: After an accepted write command, DATA_W bits are sampled on rising serial clock edges, MSB first. Exactly one write strobe then carries that word and the address. The port then waits for a new command byte.
- R4: After an accepted read command, one read strobe is issued with the address. The register word is driven out MSB first, with each bit changed on a falling serial clock edge and valid on the next rising edge.
- R5: A command byte with bit 7 set is ignored: no strobe is issued, and the next 8 bits are decoded as a fresh command byte.
- R6: Raising the select line in the middle of any byte or word ends the transfer without a write strobe. The next selected frame starts with a command byte.
- R7: A pulse on new_result sets the ready flag. While the port is selected and not driving data, the output line is low when the flag is set and high when it is clear.
- R8: The ready flag clears only when all DATA_W bits of the data register (address DATA_ADDR) have been clocked out. Reads of other registers and aborted reads leave it unchanged.
- R9: Outside streaming mode, the data register can be read again with a new command and returns the same word, even after the ready flag has cleared.
- R10: In streaming mode (cont_read high), a falling serial clock edge while the flag is set starts shifting out the data register with no command byte. Clock edges while the flag is clear shift nothing and leave the output high, so each result is read once.
- R11: If new_result arrives in the same cycle that a data-register read completes, the ready flag stays set.
- R12: dout_oe is high only while the port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Port select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data in |
| dout_rdy_n | output | 1 | Serial data out, or ready flag (active low) when not shifting |
| dout_oe | output | 1 | Output enable for dout_rdy_n |
| cont_read | input | 1 | Streaming read mode select |
| new_result | input | 1 | One-cycle pulse: data register holds a new result |
| rf_addr | output | 3 | Register-file address |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wdata | output | DATA_W | Register-file write word |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rdata | input | DATA_W | Register-file read word for rf_addr |

## Verification
The ready flag has two causes, a new result from the conversion side and a completed data-register read on the serial side, and both can act in the same system clock cycle. The bench forces this overlap by holding new_result high across the whole last data bit and the end of the frame, so the completion cycle must fall inside the pulse. It then expects the line to read low on the next idle selection. The checker also requires the flag to be set in the cycle after any cycle where both events occur.

// File: rtl/csp_pkg.sv
// Package: shared phase type and command-byte field positions for the
// command-prefixed serial register port.
package csp_pkg;

    // Frame phase of the port
    typedef enum logic [1:0] {
        PH_CMD = 2'd0,   // waiting for / shifting a command byte
        PH_WR  = 2'd1,   // shifting in a register word
        PH_RD  = 2'd2    // shifting out a register word
    } phase_t;

    localparam int CMD_BITS    = 8;
    localparam int CMD_HALT_B  = 7;   // must be zero for a valid command
    localparam int CMD_RD_B    = 6;   // 1 = read, 0 = write
    localparam int CMD_ADDR_LO = 3;   // address field lowest bit
    localparam int ADDR_W      = 3;   // address field width (bits 5:3)

endpackage

// File: rtl/csp_sync.sv
// Module: csp_sync
// Brings the asynchronous bus lines (serial clock, select, data in) into the
// system clock domain through a STAGES-deep flop chain and derives one-cycle
// rising/falling strobes for the serial clock.
// Assumes: the serial clock half period spans well over STAGES+1 system clocks.
module csp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic din_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_n_s,
    output logic din_s
);
    localparam int LANES = 3;                        // {din, cs_n, sclk}
    localparam logic [LANES-1:0] IDLE_LVL = 3'b011;  // bus idle levels

    logic [STAGES-1:0][LANES-1:0] pipe;
    logic                         sclk_prev;

    // Synchronizer chain for the three lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= IDLE_LVL;
        end else begin
            pipe[0] <= {din_i, cs_n_i, sclk_i};
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    // Previous synchronized serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= pipe[STAGES-1][0];
    end

    assign sclk_rise = pipe[STAGES-1][0] & ~sclk_prev;
    assign sclk_fall = ~pipe[STAGES-1][0] & sclk_prev;
    assign cs_n_s    = pipe[STAGES-1][1];
    assign din_s     = pipe[STAGES-1][2];

endmodule

// File: rtl/csp_frame_ctrl.sv
// Module: csp_frame_ctrl
// Frame sequencer: decodes the command byte, shifts register words in or out,
// issues register-file strobes and flags a completed data-register read.
// Assumes: synchronized inputs from csp_sync; rf_rdata valid one cycle after
// rf_addr changes; cont_read changes only while the port is idle.
module csp_frame_ctrl
    import csp_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int DATA_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_n_s,
    input  logic              din_s,
    input  logic              cont_read,
    input  logic              ready,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_rd_en,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rd_done,
    output logic              drv_data,
    output logic              out_bit
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0]  WORD_LAST = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] DAT_ADDR  = ADDR_W'(DATA_ADDR);

    phase_t              phase;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-2:0]   sh_in;
    logic [DATA_W-1:0]   sh_out;
    logic                load_pend;
    logic [ADDR_W-1:0]   addr_q;

    // Fields of the byte completing on this rising edge
    logic                cmd_halt;
    logic                cmd_rd;
    logic [ADDR_W-1:0]   cmd_addr;
    assign cmd_halt = sh_in[CMD_HALT_B-1];
    assign cmd_rd   = sh_in[CMD_RD_B-1];
    assign cmd_addr = sh_in[CMD_ADDR_LO+ADDR_W-2 -: ADDR_W];

    assign rf_addr = addr_q;

    // Frame sequencing, shifting and register-file strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            sh_in     <= '0;
            sh_out    <= '0;
            load_pend <= 1'b0;
            addr_q    <= '0;
            rf_wr_en  <= 1'b0;
            rf_rd_en  <= 1'b0;
            rf_wdata  <= '0;
            rd_done   <= 1'b0;
            drv_data  <= 1'b0;
            out_bit   <= 1'b1;
        end else begin
            rf_wr_en <= 1'b0;
            rf_rd_en <= 1'b0;
            rd_done  <= 1'b0;
            if (phase == PH_CMD && cont_read) addr_q <= DAT_ADDR;
            if (cs_n_s) begin
                phase     <= PH_CMD;
                cnt       <= '0;
                load_pend <= 1'b0;
                drv_data  <= 1'b0;
            end else begin
                case (phase)
                    PH_CMD: begin
                        if (cont_read) begin
                            if (sclk_fall && ready) begin
                                out_bit  <= rf_rdata[DATA_W-1];
                                sh_out   <= {rf_rdata[DATA_W-2:0], 1'b0};
                                drv_data <= 1'b1;
                                rf_rd_en <= 1'b1;
                                cnt      <= '0;
                                phase    <= PH_RD;
                            end
                        end else if (sclk_rise) begin
                            sh_in <= {sh_in[DATA_W-3:0], din_s};
                            if (cnt == CMD_LAST) begin
                                cnt <= '0;
                                if (!cmd_halt) begin
                                    addr_q    <= cmd_addr;
                                    phase     <= cmd_rd ? PH_RD : PH_WR;
                                    load_pend <= cmd_rd;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_WR: begin
                        if (sclk_rise) begin
                            sh_in <= {sh_in[DATA_W-3:0], din_s};
                            if (cnt == WORD_LAST) begin
                                rf_wr_en <= 1'b1;
                                rf_wdata <= {sh_in, din_s};
                                cnt      <= '0;
                                phase    <= PH_CMD;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_RD: begin
                        if (load_pend) begin
                            sh_out    <= rf_rdata;
                            rf_rd_en  <= 1'b1;
                            load_pend <= 1'b0;
                        end else begin
                            if (sclk_fall) begin
                                out_bit  <= sh_out[DATA_W-1];
                                sh_out   <= {sh_out[DATA_W-2:0], 1'b0};
                                drv_data <= 1'b1;
                            end
                            if (sclk_rise) begin
                                if (cnt == WORD_LAST) begin
                                    cnt      <= '0;
                                    phase    <= PH_CMD;
                                    drv_data <= 1'b0;
                                    rd_done  <= (addr_q == DAT_ADDR);
                                end else begin
                                    cnt <= cnt + 1'b1;
                                end
                            end
                        end
                    end
                    default: phase <= PH_CMD;
                endcase
            end
        end
    end

endmodule

// File: rtl/csp_ready.sv
// Module: csp_ready
// Holds the result-ready flag: set by a new result, cleared by a completed
// data-register read; a new result in the same cycle wins.
// Assumes: both inputs are single-cycle pulses in the system clock domain.
module csp_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic new_result,
    input  logic rd_done,
    output logic ready
);
    // Ready flag update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)          ready <= 1'b0;
        else if (new_result) ready <= 1'b1;
        else if (rd_done)    ready <= 1'b0;
    end

endmodule

// File: rtl/cmd_serial_port.sv
// Module: cmd_serial_port (top)
// Device-side serial register port: command byte then data word, with the
// output line doubling as an active-low result-ready flag.
// Assumes: serial clock idles high and runs far below the system clock.
module cmd_serial_port
    import csp_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int DATA_ADDR   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout_rdy_n,
    output logic              dout_oe,
    input  logic              cont_read,
    input  logic              new_result,
    output logic [2:0]        rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_rd_en,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic sclk_rise, sclk_fall, cs_n_s, din_s;
    logic ready_q, rd_done, drv_data, out_bit;

    csp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .din_i     (din),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_n_s    (cs_n_s),
        .din_s     (din_s)
    );

    csp_frame_ctrl #(.DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_n_s    (cs_n_s),
        .din_s     (din_s),
        .cont_read (cont_read),
        .ready     (ready_q),
        .rf_addr   (rf_addr),
        .rf_wr_en  (rf_wr_en),
        .rf_wdata  (rf_wdata),
        .rf_rd_en  (rf_rd_en),
        .rf_rdata  (rf_rdata),
        .rd_done   (rd_done),
        .drv_data  (drv_data),
        .out_bit   (out_bit)
    );

    csp_ready u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_result (new_result),
        .rd_done    (rd_done),
        .ready      (ready_q)
    );

    // Output line: data bit while shifting, else inverted ready flag
    always_comb begin
        if (cs_n_s)        dout_rdy_n = 1'b1;
        else if (drv_data) dout_rdy_n = out_bit;
        else               dout_rdy_n = ~ready_q;
    end

    assign dout_oe = ~cs_n_s;

endmodule

// File: rtl/cmd_serial_port_chk.sv
// Module: cmd_serial_port_chk
// Property checker for cmd_serial_port, attached through bind.
module cmd_serial_port_chk #(
    parameter int DATA_ADDR = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_s,
    input logic       new_result,
    input logic       rd_done,
    input logic       ready_q,
    input logic       drv_data,
    input logic       rf_wr_en,
    input logic       rf_rd_en,
    input logic [2:0] rf_addr,
    input logic       cont_read
);
    // R7
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_result |=> ready_q);

    // R8
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !new_result) |=> !ready_q);

    // R11
    ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && new_result) |=> ready_q);

    // R6
    abort_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !drv_data);

    // R6
    wr_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !rf_wr_en);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_wr_en, rf_rd_en}));

    // R10
    cread_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_read && rf_rd_en) |-> (rf_addr == 3'(DATA_ADDR)));

endmodule

bind cmd_serial_port cmd_serial_port_chk #(.DATA_ADDR(DATA_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .new_result (new_result),
    .rd_done    (rd_done),
    .ready_q    (ready_q),
    .drv_data   (drv_data),
    .rf_wr_en   (rf_wr_en),
    .rf_rd_en   (rf_rd_en),
    .rf_addr    (rf_addr),
    .cont_read  (cont_read)
);

// File: tb/sim_cmd_serial_port.sv
// Bench for cmd_serial_port: seeded random register traffic plus directed
// corner cases, checked against values computed here.
module sim_cmd_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int DADDR      = 3;
    localparam int HALF       = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic          cont_read = 1'b0, new_result = 1'b0;
    logic          dout_rdy_n, dout_oe;
    logic [2:0]    rf_addr;
    logic          rf_wr_en, rf_rd_en;
    logic [DW-1:0] rf_wdata, rf_rdata;

    logic [DW-1:0] regs [8];
    logic [DW-1:0] conv_word = '0;
    logic [DW-1:0] exp_regs [8];
    int            wr_cnt = 0, rd_cnt = 0;
    logic [2:0]    last_wr_addr;
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_serial_port #(.DATA_W(DW), .DATA_ADDR(DADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout_rdy_n(dout_rdy_n), .dout_oe(dout_oe), .cont_read(cont_read),
        .new_result(new_result), .rf_addr(rf_addr), .rf_wr_en(rf_wr_en),
        .rf_wdata(rf_wdata), .rf_rd_en(rf_rd_en), .rf_rdata(rf_rdata)
    );

    // Bench register file: data register comes from the conversion model
    assign rf_rdata = (rf_addr == 3'(DADDR)) ? conv_word : regs[rf_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] <= '0;
        end else begin
            if (rf_wr_en) begin
                regs[rf_addr] <= rf_wdata;
                wr_cnt++;
                last_wr_addr <= rf_addr;
            end
            if (rf_rd_en) rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        din  = b;
        repeat (HALF) @(negedge clk);
        o    = dout_rdy_n;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic shift(input logic [31:0] v, input int n, output logic [31:0] got);
        logic o;
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sbit(v[i], o);
            got[i] = o;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic desel();
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [7:0] cmd(input bit rd, input logic [2:0] a);
        logic [2:0] junk = 3'($urandom);
        return {1'b0, rd, a, junk};
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
        logic [31:0] g;
        sel();
        shift({24'h0, cmd(1'b0, a)}, 8, g);
        shift({8'h0, d}, DW, g);
        desel();
        exp_regs[a] = d;
    endtask

    task automatic rd_reg(input logic [2:0] a, input bit hold_last, output logic [DW-1:0] w);
        logic [31:0] g;
        logic o;
        sel();
        shift({24'h0, cmd(1'b1, a)}, 8, g);
        shift(32'h0, DW - 1, g);
        if (hold_last) new_result = 1'b1;
        sbit(1'b0, o);
        w = {g[DW-2:0], o};
        repeat (6) @(negedge clk);
        new_result = 1'b0;
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic push_result(input logic [DW-1:0] v);
        @(negedge clk);
        conv_word  = v;
        new_result = 1'b1;
        @(negedge clk);
        new_result = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_flag(output logic f);
        sel();
        f = dout_rdy_n;
        desel();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w, d;
        logic [2:0]    a;
        logic [31:0]   g;
        logic          f;
        int            wc, rc;
        void'($urandom(32'd7351));
        for (int i = 0; i < 8; i++) exp_regs[i] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dout_rdy_n == 1'b1, "R1 line high", 32'(dout_rdy_n), 1);
        chk(dout_oe == 1'b0, "R1 oe low", 32'(dout_oe), 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes", 32'(wr_cnt + rd_cnt), 0);

        // R12 / R7: selected, no result -> enable high, line high
        sel();
        chk(dout_oe == 1'b1, "R12 oe while selected", 32'(dout_oe), 1);
        chk(dout_rdy_n == 1'b1, "R7 no result line high", 32'(dout_rdy_n), 1);
        desel();
        chk(dout_oe == 1'b0, "R12 oe after deselect", 32'(dout_oe), 0);

        // R2 R3 R4: seeded random write/read-back traffic
        for (int it = 0; it < 20; it++) begin
            a = 3'($urandom_range(0, 6));
            if (a >= 3'(DADDR)) a = a + 3'd1;
            d = DW'($urandom);
            wc = wr_cnt;
            wr_reg(a, d);
            chk(wr_cnt == wc + 1 && last_wr_addr == a, "R3 one write strobe at address",
                32'(last_wr_addr), 32'(a));
            rc = rd_cnt;
            rd_reg(a, 1'b0, w);
            chk(w == exp_regs[a], "R4 read word MSB first", 32'(w), 32'(exp_regs[a]));
            chk(rd_cnt == rc + 1, "R4 one read strobe", 32'(rd_cnt - rc), 1);
        end

        // R5: byte with bit 7 set ignored, next byte decoded as command
        wc = wr_cnt;
        rc = rd_cnt;
        d  = 24'hA5C3_0F;
        sel();
        shift({24'h0, 8'hC8}, 8, g);
        chk(wr_cnt == wc && rd_cnt == rc, "R5 halted byte no strobe", 32'(wr_cnt - wc + rd_cnt - rc), 0);
        shift({24'h0, cmd(1'b0, 3'd5)}, 8, g);
        shift({8'h0, d}, DW, g);
        desel();
        exp_regs[5] = d;
        chk(wr_cnt == wc + 1 && last_wr_addr == 3'd5, "R5 following byte accepted", 32'(last_wr_addr), 5);
        rd_reg(3'd5, 1'b0, w);
        chk(w == d, "R5 written word", 32'(w), 32'(d));

        // R6: abort mid-word, then mid-command
        wc = wr_cnt;
        sel();
        shift({24'h0, cmd(1'b0, 3'd6)}, 8, g);
        shift(32'h0000_3FF, 10, g);
        desel();
        sel();
        shift(32'h0000_0005, 5, g);
        desel();
        chk(wr_cnt == wc, "R6 no write after abort", 32'(wr_cnt - wc), 0);
        wr_reg(3'd6, 24'h13579B);
        chk(wr_cnt == wc + 1 && last_wr_addr == 3'd6, "R6 next frame starts with command", 32'(last_wr_addr), 6);
        rd_reg(3'd6, 1'b0, w);
        chk(w == 24'h13579B, "R6 register after abort", 32'(w), 32'h13579B);

        // R7 R8 R9: ready flag around data-register reads
        push_result(24'h8E01F7);
        idle_flag(f);
        chk(f == 1'b0, "R7 ready shown low", 32'(f), 0);
        rd_reg(3'd1, 1'b0, w);
        idle_flag(f);
        chk(f == 1'b0, "R8 other read keeps ready", 32'(f), 0);
        sel();
        shift({24'h0, cmd(1'b1, 3'(DADDR))}, 8, g);
        shift(32'h0, 12, g);
        desel();
        idle_flag(f);
        chk(f == 1'b0, "R8 aborted read keeps ready", 32'(f), 0);
        rd_reg(3'(DADDR), 1'b0, w);
        chk(w == 24'h8E01F7, "R4 data register word", 32'(w), 32'h8E01F7);
        idle_flag(f);
        chk(f == 1'b1, "R8 full read clears ready", 32'(f), 1);
        rd_reg(3'(DADDR), 1'b0, w);
        chk(w == 24'h8E01F7, "R9 repeat read same word", 32'(w), 32'h8E01F7);

        // R11: new result held across read completion
        push_result(24'h0F0F0F);
        rd_reg(3'(DADDR), 1'b1, w);
        chk(w == 24'h0F0F0F, "R11 word read", 32'(w), 32'h0F0F0F);
        idle_flag(f);
        chk(f == 1'b0, "R11 ready survives coincident completion", 32'(f), 0);
        rd_reg(3'(DADDR), 1'b0, w);
        idle_flag(f);
        chk(f == 1'b1, "R8 cleared after next read", 32'(f), 1);

        // R10: streaming reads without command bytes
        cont_read = 1'b1;
        repeat (4) @(negedge clk);
        push_result(24'hC0FFEE);
        rc = rd_cnt;
        sel();
        shift(32'h0, DW, g);
        chk(g[DW-1:0] == 24'hC0FFEE, "R10 streamed word", g, 32'hC0FFEE);
        repeat (6) @(negedge clk);
        chk(dout_rdy_n == 1'b1, "R10 line high after read", 32'(dout_rdy_n), 1);
        shift(32'h0, DW, g);
        chk(g[DW-1:0] == 24'hFFFFFF && rd_cnt == rc + 1, "R10 no second read of result",
            g, 32'hFFFFFF);
        desel();
        push_result(24'h5A5A12);
        sel();
        shift(32'h0, DW, g);
        desel();
        chk(g[DW-1:0] == 24'h5A5A12, "R10 next streamed word", g, 32'h5A5A12);
        cont_read = 1'b0;
        repeat (4) @(negedge clk);
        rd_reg(3'd6, 1'b0, w);
        chk(w == 24'h13579B, "R2 command mode restored", 32'(w), 32'h13579B);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule